// File: doc/BRIEF.md
# Zero-Turnaround SRAM Host Controller

This block sits between a request stream and a pipelined synchronous SRAM whose data phase trails its command phase by two clock cycles and which allows a read and a write on consecutive cycles. Each accepted request becomes one command cycle on the memory pins. The block keeps a two-stage record of the commands it has issued. It uses that record to drive write data in the second enabled cycle after a write command, and to hand read data back in the second enabled cycle after a read command. Read results come back in request order and carry no tag.

Both edges are valid/ready. A request is taken in any cycle where `req_valid` and `req_ready` are both high, and the requester must hold the request until it is taken. The response side presents `rsp_valid` with `rsp_rdata` straight from the memory's read bus. When the consumer holds `rsp_ready` low while a response is waiting, the block drops the memory clock enable. This freezes the memory pipeline and the block's own tracking, so the read word stays on the bus until it is taken. In the same cycle `req_ready` falls, because no command can be issued while the memory is frozen. The path from `rsp_ready` to `req_ready` is combinational.

A request that continues the previous cycle's request becomes a burst advance instead of a new address load. To continue, it must have the same direction, the next address, and fall in the same four-word aligned block. The memory's internal counter then supplies the address.

Top module: `zbt_host_ctrl`

## Requirements
- R1: After reset `rsp_valid`, `mem_dq_oe` and `mem_sel` are low and `req_ready` is high.
- R2: The write data of a write command is on `mem_dq_out` during the second enabled cycle after the command. Mask bit i enables bits 8i+7..8i, and lanes whose mask bit is 0 keep their old memory contents.
- R3: Each read returns, in request order, the word on `mem_dq_in` during the second enabled cycle after its command, and that word equals the value written most recently before the read was accepted.
- R4: While `rsp_ready` is high, `req_ready` is high in every cycle, whatever the mix of reads, writes and idles.
- R5: `mem_adv` is 1 on an accepted request exactly when three things hold: the previous enabled cycle also accepted a request, both requests have the same direction, and the new address equals the old address plus 1 with its two low bits not both 0. Otherwise it is 0, which loads `mem_addr`.
- R6: While `rsp_valid` is high and `rsp_ready` is low, `mem_clk_en` and `req_ready` are low and `rsp_valid` stays high, and no read word is lost.
- R7: `mem_dq_oe` is high only in write data cycles, never together with `rsp_valid`.
- R8: `mem_sel` is high exactly in the cycles where a request is accepted.
- R9: On an accepted request `mem_we` is 1 for a write and 0 for a read. `mem_be` equals the request mask on writes and is all zero on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle if valid |
| req_addr | input | AW | Word address |
| req_write | input | 1 | 1 write, 0 read |
| req_mask | input | DW/LANE | Byte-lane write mask |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read word present |
| rsp_ready | input | 1 | Consumer takes the read word |
| rsp_rdata | output | DW | Read word |
| mem_clk_en | output | 1 | Memory clock enable, high to run |
| mem_sel | output | 1 | Memory select, high on a command cycle |
| mem_we | output | 1 | Command direction, 1 write |
| mem_adv | output | 1 | 1 advance burst counter, 0 load address |
| mem_addr | output | AW | Command address |
| mem_be | output | DW/LANE | Byte write enables |
| mem_dq_out | output | DW | Write data to the bus |
| mem_dq_oe | output | 1 | Write data drive enable |
| mem_dq_in | input | DW | Read data from the bus |

## Verification
Two functions meet in one cycle. A new command can be issued, possibly as a burst advance, in the same cycle in which an older read's response is stalled, or in which an older write's data is on the bus. The bench provokes both with dense random traffic and a random `rsp_ready`, and with a directed stall that holds `rsp_ready` low behind two reads. It judges the result with a cycle model of the memory, which writes and reads only through the block's pins, and with a scoreboard of the values each read must return.

// File: rtl/zbt_host_pkg.sv
package zbt_host_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_burst_judge.sv
module zbt_burst_judge #(
  parameter int AW = 18,
  parameter int BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          issue,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  output logic          adv
);
  localparam int BB = $clog2(BURST_LEN);

  logic          prev_v;
  logic          prev_wr;
  logic [AW-1:0] prev_addr;

  // advance only inside one aligned block, same direction, next word
  always_comb begin
    adv = issue && prev_v && (prev_wr == is_wr) &&
          (addr == prev_addr + AW'(1)) && (addr[BB-1:0] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_v    <= 1'b0;
      prev_wr   <= 1'b0;
      prev_addr <= '0;
    end else if (step) begin
      prev_v    <= issue;
      prev_wr   <= is_wr;
      prev_addr <= addr;
    end
  end
endmodule

// File: rtl/zbt_align_pipe.sv
module zbt_align_pipe
  import zbt_host_pkg::*;
#(
  parameter int DW = 32,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  op_e           head_op,
  input  logic [DW-1:0] head_data,
  output op_e           tail_op,
  output logic [DW-1:0] tail_data
);
  op_e           op_q  [DEPTH];
  logic [DW-1:0] dat_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    op_e           op_in;
    logic [DW-1:0] dat_in;
    if (i == 0) begin : g_first
      assign op_in  = head_op;
      assign dat_in = head_data;
    end else begin : g_next
      assign op_in  = op_q[i-1];
      assign dat_in = dat_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        op_q[i]  <= OP_IDLE;
        dat_q[i] <= '0;
      end else if (step) begin
        op_q[i]  <= op_in;
        dat_q[i] <= dat_in;
      end
    end
  end

  assign tail_op   = op_q[DEPTH-1];
  assign tail_data = dat_q[DEPTH-1];
endmodule

// File: rtl/zbt_host_ctrl.sv
module zbt_host_ctrl
  import zbt_host_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 32,
  parameter int LANE = 8,
  parameter int BURST_LEN = 4,
  parameter int LATENCY = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_addr,
  input  logic                 req_write,
  input  logic [DW/LANE-1:0]   req_mask,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 mem_clk_en,
  output logic                 mem_sel,
  output logic                 mem_we,
  output logic                 mem_adv,
  output logic [AW-1:0]        mem_addr,
  output logic [DW/LANE-1:0]   mem_be,
  output logic [DW-1:0]        mem_dq_out,
  output logic                 mem_dq_oe,
  input  logic [DW-1:0]        mem_dq_in
);
  localparam int NB = DW / LANE;

  logic          step;
  logic          issue;
  op_e           head_op;
  op_e           tail_op;
  logic [DW-1:0] tail_data;
  logic [DW-1:0] head_data;
  logic          adv;

  // freeze the memory and the tracking while a read word waits
  assign step  = !((tail_op == OP_RD) && !rsp_ready);
  assign issue = req_valid && step;

  always_comb begin
    head_op   = OP_IDLE;
    head_data = '0;
    if (issue) begin
      head_op = req_write ? OP_WR : OP_RD;
      if (req_write) head_data = req_wdata;
    end
  end

  zbt_burst_judge #(.AW(AW), .BURST_LEN(BURST_LEN)) u_judge (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .issue (issue),
    .is_wr (req_write),
    .addr  (req_addr),
    .adv   (adv)
  );

  zbt_align_pipe #(.DW(DW), .DEPTH(LATENCY)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .head_op   (head_op),
    .head_data (head_data),
    .tail_op   (tail_op),
    .tail_data (tail_data)
  );

  assign req_ready  = step;
  assign mem_clk_en = step;
  assign mem_sel    = issue;
  assign mem_we     = issue && req_write;
  assign mem_adv    = adv;
  assign mem_addr   = issue ? req_addr : '0;
  assign mem_be     = (issue && req_write) ? req_mask : {NB{1'b0}};
  assign mem_dq_oe  = (tail_op == OP_WR);
  assign mem_dq_out = mem_dq_oe ? tail_data : '0;
  assign rsp_valid  = (tail_op == OP_RD);
  assign rsp_rdata  = mem_dq_in;
endmodule

module zbt_host_ctrl_chk #(
  parameter int DW = 32,
  parameter int LANE = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               mem_clk_en,
  input logic               mem_sel,
  input logic               mem_we,
  input logic               mem_adv,
  input logic [DW/LANE-1:0] mem_be,
  input logic               mem_dq_oe
);
  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (!mem_clk_en && !req_ready));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);
  assert_flow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> req_ready);
  assert_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !rsp_valid);
  assert_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel |-> (req_valid && req_ready));
  assert_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_adv |-> (mem_sel && mem_clk_en));
  assert_be_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel && !mem_we) |-> (mem_be == '0));
endmodule

bind zbt_host_ctrl zbt_host_ctrl_chk #(.DW(DW), .LANE(LANE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .mem_clk_en (mem_clk_en),
  .mem_sel    (mem_sel),
  .mem_we     (mem_we),
  .mem_adv    (mem_adv),
  .mem_be     (mem_be),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_zbt_host_ctrl.sv
`timescale 1ns/1ps
module sim_zbt_host_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [3:0]  req_mask = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        mem_clk_en, mem_sel, mem_we, mem_adv, mem_dq_oe;
  logic [17:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_dq_out, mem_dq_in;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  zbt_host_ctrl u0 (.*);

  // memory model driven only through the pins
  logic [31:0] bmem [64];
  logic        p1v, p1w, p2v, p2w;
  logic [5:0]  p1a, p2a, ba, na;
  logic [3:0]  p1b, p2b;

  always @(posedge clk) begin
    if (!rst_n) begin
      p1v <= 0; p1w <= 0; p2v <= 0; p2w <= 0;
      p1a <= 0; p2a <= 0; ba <= 0; p1b <= 0; p2b <= 0;
    end else if (mem_clk_en) begin
      if (p2v && p2w)
        for (int l = 0; l < 4; l++)
          if (p2b[l]) bmem[p2a][8*l +: 8] <= mem_dq_out[8*l +: 8];
      na = mem_adv ? {ba[5:2], ba[1:0] + 2'd1} : mem_addr[5:0];
      if (mem_sel) ba <= na;
      p1v <= mem_sel; p1w <= mem_we; p1a <= na; p1b <= mem_be;
      p2v <= p1v; p2w <= p1w; p2a <= p1a; p2b <= p1b;
    end
  end
  assign mem_dq_in = (p2v && !p2w) ? bmem[p2a] : 32'hDEAD_BEEF;

  // bench reference
  logic [31:0] refm [64];
  logic [31:0] expq [256];
  int qh = 0, qt = 0;
  bit ex_pv = 0, ex_pw = 0;
  logic [17:0] ex_pa = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] m);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (m[l]) r[8*l +: 8] = nw[8*l +: 8];
    return r;
  endfunction

  task automatic sample(output bit acc);
    bit exp_adv;
    acc = req_valid && req_ready;
    if (rsp_ready) chk(req_ready === 1'b1, "R4 ready", {31'b0, req_ready}, 32'd1);
    if (rsp_valid && !rsp_ready)
      chk(!mem_clk_en && !req_ready, "R6 stall", {30'b0, mem_clk_en, req_ready}, 32'd0);
    chk(mem_dq_oe === (p2v && p2w), "R7 drive", {31'b0, mem_dq_oe}, {31'b0, p2v && p2w});
    chk(mem_sel === acc, "R8 select", {31'b0, mem_sel}, {31'b0, acc});
    if (acc) begin
      exp_adv = ex_pv && (ex_pw == req_write) && (req_addr == ex_pa + 18'd1) && (req_addr[1:0] != 2'd0);
      chk(mem_adv === exp_adv, "R5 advance", {31'b0, mem_adv}, {31'b0, exp_adv});
      chk(mem_we === req_write && mem_be === (req_write ? req_mask : 4'h0), "R9 we/be",
          {27'b0, mem_we, mem_be}, {27'b0, req_write, req_write ? req_mask : 4'h0});
      if (req_write) refm[req_addr[5:0]] = merge(refm[req_addr[5:0]], req_wdata, req_mask);
      else begin expq[qt % 256] = refm[req_addr[5:0]]; qt++; end
    end
    if (req_ready) begin ex_pv = acc; ex_pw = req_write; ex_pa = req_addr; end
    if (rsp_valid && rsp_ready) begin
      if (qh == qt) chk(1'b0, "R3 unexpected response", rsp_rdata, 32'h0);
      else begin
        chk(rsp_rdata === expq[qh % 256], "R3/R2 read data", rsp_rdata, expq[qh % 256]);
        qh++;
      end
    end
  endtask

  task automatic send(input bit v, input bit wr, input logic [5:0] a, input logic [3:0] m,
                      input logic [31:0] d, input int pct);
    bit acc;
    do begin
      @(negedge clk);
      req_valid = v; req_write = wr; req_addr = {12'b0, a}; req_mask = m; req_wdata = d;
      rsp_ready = (($urandom % 100) < pct);
      #3;
      sample(acc);
    end while (v && !acc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R3 act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [5:0] last;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      bmem[i] = (i * 32'h0101_0101) ^ 32'h5A00_00A5;
      refm[i] = bmem[i];
    end
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready === 1'b1, "R1 ready", {31'b0, req_ready}, 32'd1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk(mem_dq_oe === 1'b0, "R1 oe", {31'b0, mem_dq_oe}, 32'd0);
    chk(mem_sel === 1'b0, "R1 sel", {31'b0, mem_sel}, 32'd0);
    rst_n = 1'b1;
    // burst of writes then reads in one block
    for (int a = 0; a < 4; a++) send(1, 1, 6'(a), 4'hF, 32'hC0DE_0000 + a, 100);
    for (int a = 0; a < 4; a++) send(1, 0, 6'(a), 4'h0, 0, 100);
    // block crossing, then write with partial mask and immediate read
    send(1, 0, 6'd3, 0, 0, 100);
    send(1, 0, 6'd4, 0, 0, 100);
    send(1, 1, 6'd5, 4'b0101, 32'h1122_3344, 100);
    send(1, 0, 6'd5, 0, 0, 100);
    // stall behind two reads
    send(1, 0, 6'd10, 0, 0, 100);
    send(1, 0, 6'd11, 0, 0, 100);
    for (int k = 0; k < 5; k++) send(0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) send(0, 0, 0, 0, 0, 100);
    // random mixed traffic
    last = 6'd0;
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] a;
      a = (($urandom % 3) == 0) ? last + 6'd1 : 6'($urandom);
      if (($urandom % 8) == 0) send(0, 0, 0, 0, 0, 70);
      else begin
        send(1, 1'($urandom), a, 4'($urandom), $urandom, 70);
        last = a;
      end
    end
    for (int k = 0; k < 6; k++) send(0, 0, 0, 0, 0, 100);
    // read back every word
    for (int a = 0; a < 64; a++) send(1, 0, 6'(a), 0, 0, 100);
    for (int k = 0; k < 6; k++) send(0, 0, 0, 0, 0, 100);
    chk(qh == qt, "R3 all responses returned", qh, qt);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule